// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block produces the external reset pulse of a watchdog. When the watchdog countdown expires, a one-cycle timeout strobe arrives. The block then drives a pulse on the external reset output. The pulse is timed by a 1 MHz tick input, and its length comes from a duration field held in a 32-bit configuration register. A simple write/read port gives access to that register.

Two properties of the output are held in bits 31 and 30 of the same register: the polarity (active-high or active-low) and the drive mode (push-pull or open-drain). These two bits change only when one of four protected codes is written into the top byte. Any write, whatever its top byte, also loads the duration field from the low bits. Open-drain drive is modelled by an output-enable signal next to the data output.

A parameter selects a wide 20-bit duration field or a narrow 8-bit one.

Top module: `wdt_ext_pulse`

## Requirements
- R1: After reset the register reads 0x000000FF, which means active-low, open-drain, and a duration of 255. The output enable is low.
- R2: Every write loads the duration field, bits 19:0 (bits 7:0 in the narrow option), from the written data. The field reads back the value written.
- R3: Writing top byte 0xA5 sets bit 31 (active-high). Writing top byte 0x5A clears it (active-low).
- R4: Writing top byte 0xA8 sets bit 30 (push-pull). Writing top byte 0x8A clears it (open-drain).
- R5: Any other top-byte value leaves bits 31 and 30 unchanged. Bits 29:20 (29:8 in the narrow option) always read zero.
- R6: A timeout strobe in an idle cycle starts a pulse on the next clock edge. The pulse stays asserted for exactly (duration + 1) ticks.
- R7: A timeout strobe that arrives during a pulse is ignored. The pulse length is captured when the pulse starts, so a write to the register during a pulse does not change the length of that pulse.
- R8: In push-pull mode the output enable is always high. The data output is at the asserted level during a pulse and at the opposite level otherwise.
- R9: In open-drain mode the output enable is high only during a pulse. The data output stays at the asserted level at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| tick_i | input | 1 | 1 MHz timebase tick, one cycle wide |
| timeout_i | input | 1 | Watchdog expiry strobe |
| ext_rst_o | output | 1 | External reset data output |
| ext_rst_oe_o | output | 1 | External reset output enable |

## Verification
A register write takes effect at the clock edge that samples it, so the read data is checked one cycle after the strobe has been dropped. A timeout strobe asserts the pulse at the edge that samples it. Pulse length is not counted in cycles. A monitor process samples the outputs on falling edges and counts the ticks seen while the pulse is asserted. When the pulse deasserts, it compares that count with the length the driver queued when it issued the strobe. Drive-mode checks are taken on a falling edge a few cycles inside a pulse, or while the block is idle, and never in the cycle the pulse changes.

// File: rtl/wdt_pulse_pkg.sv
package wdt_pulse_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [7:0] CODE_ACT_HIGH  = 8'hA5;
  localparam logic [7:0] CODE_ACT_LOW   = 8'h5A;
  localparam logic [7:0] CODE_PUSH_PULL = 8'hA8;
  localparam logic [7:0] CODE_OPEN_DRN  = 8'h8A;
  localparam logic [7:0] DUR_RESET      = 8'hFF;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } out_mode_t;
endpackage

// File: rtl/wdt_pulse_cfg.sv
module wdt_pulse_cfg
  import wdt_pulse_pkg::*;
#(
  parameter int unsigned DUR_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output out_mode_t        mode_o,
  output logic [DUR_W-1:0] dur_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [7:0] top_byte;
  assign top_byte = wr_data_i[REG_W-1 -: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      dur_o  <= DUR_W'(DUR_RESET);
    end else if (wr_en_i) begin
      dur_o <= wr_data_i[DUR_W-1:0];
      // protected codes only; anything else keeps the mode bits
      unique case (top_byte)
        CODE_ACT_HIGH:  mode_o.act_high  <= 1'b1;
        CODE_ACT_LOW:   mode_o.act_high  <= 1'b0;
        CODE_PUSH_PULL: mode_o.push_pull <= 1'b1;
        CODE_OPEN_DRN:  mode_o.push_pull <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[REG_W-1]     = mode_o.act_high;
    rd_data_o[REG_W-2]     = mode_o.push_pull;
    rd_data_o[DUR_W-1:0]   = dur_o;
  end
endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
  parameter int unsigned DUR_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             timeout_i,
  input  logic             tick_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             active_o,
  output logic [DUR_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
    end else if (!active_o) begin
      if (timeout_i) begin
        active_o <= 1'b1;
        cnt_o    <= dur_i;
      end
    end else if (tick_i) begin
      if (cnt_o == '0) active_o <= 1'b0;
      else             cnt_o    <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse_drive.sv
module wdt_pulse_drive
  import wdt_pulse_pkg::*;
(
  input  out_mode_t mode_i,
  input  logic      active_i,
  output logic      ext_o,
  output logic      oe_o
);
  always_comb begin
    if (mode_i.push_pull) begin
      oe_o  = 1'b1;
      ext_o = active_i ? mode_i.act_high : ~mode_i.act_high;
    end else begin
      oe_o  = active_i;
      ext_o = mode_i.act_high;
    end
  end
endmodule

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse
  import wdt_pulse_pkg::*;
#(
  parameter bit WIDE_DUR = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        tick_i,
  input  logic        timeout_i,
  output logic        ext_rst_o,
  output logic        ext_rst_oe_o
);
  localparam int unsigned DUR_W = WIDE_DUR ? 20 : 8;

  out_mode_t        mode;
  logic [DUR_W-1:0] dur;
  logic             pulse_on;
  logic [DUR_W-1:0] cnt;

  wdt_pulse_cfg #(.DUR_W(DUR_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode),
    .dur_o     (dur),
    .rd_data_o (rd_data_o)
  );

  wdt_pulse_timer #(.DUR_W(DUR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .timeout_i (timeout_i),
    .tick_i    (tick_i),
    .dur_i     (dur),
    .active_o  (pulse_on),
    .cnt_o     (cnt)
  );

  wdt_pulse_drive u_drive (
    .mode_i   (mode),
    .active_i (pulse_on),
    .ext_o    (ext_rst_o),
    .oe_o     (ext_rst_oe_o)
  );
endmodule

// File: rtl/wdt_ext_pulse_chk.sv
module wdt_ext_pulse_chk #(
  parameter int unsigned DUR_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic [31:0]      rd_data_o,
  input logic             tick_i,
  input logic             timeout_i,
  input logic             ext_rst_o,
  input logic             ext_rst_oe_o,
  input logic             pulse_on,
  input logic [DUR_W-1:0] cnt
);
  assert_act_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'hA5 |=> rd_data_o[31]);
  assert_open_drn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'h8A |=> !rd_data_o[30]);
  assert_keep_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (wr_data_i[31:24] == 8'hA5 || wr_data_i[31:24] == 8'h5A ||
                  wr_data_i[31:24] == 8'hA8 || wr_data_i[31:24] == 8'h8A))
    |=> $stable(rd_data_o[31:30]));
  assert_zero_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[29:DUR_W] == '0);
  assert_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_on && timeout_i |=> pulse_on);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_on && !tick_i |=> pulse_on && $stable(cnt));
  assert_pp_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[30] |-> ext_rst_oe_o);
  assert_od_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[30] |-> ext_rst_o == rd_data_o[31] && ext_rst_oe_o == pulse_on);
endmodule

bind wdt_ext_pulse wdt_ext_pulse_chk #(.DUR_W(DUR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .tick_i       (tick_i),
  .timeout_i    (timeout_i),
  .ext_rst_o    (ext_rst_o),
  .ext_rst_oe_o (ext_rst_oe_o),
  .pulse_on     (pulse_on),
  .cnt          (cnt)
);

// File: tb/test_wdt_ext_pulse.sv
module test_wdt_ext_pulse;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic        timeout = 1'b0;
  logic        ext_rst, ext_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit m_high = 1'b0;
  bit m_pp   = 1'b0;
  bit in_pulse = 1'b0;
  int tick_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_ext_pulse i_wdt_ext_pulse (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd_data),
    .tick_i       (tick),
    .timeout_i    (timeout),
    .ext_rst_o    (ext_rst),
    .ext_rst_oe_o (ext_oe)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // tick every fourth cycle
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      tick = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  // monitor: ticks counted while asserted, compared at deassertion
  always @(negedge clk) begin
    bit asserted;
    asserted = m_pp ? (ext_oe && ext_rst == m_high) : ext_oe;
    if (rst_n && asserted) begin
      in_pulse = 1'b1;
      if (tick) tick_seen++;
    end else if (in_pulse) begin
      in_pulse = 1'b0;
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected pulse", tick_seen, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(tick_seen == e, "R6 pulse ticks", tick_seen, e);
      end
      tick_seen = 0;
    end
  end

  task automatic reg_write(input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic fire(input int exp_len, input bit push);
    if (push) exp_q.push_back(exp_len);
    @(posedge clk); #1;
    timeout = 1'b1;
    @(posedge clk); #1;
    timeout = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || in_pulse) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_data == 32'h0000_00FF, "R1 reset read", rd_data, 32'hFF);
    check(ext_oe == 1'b0, "R1 reset oe", ext_oe, 0);
    // R9 idle open-drain, active-low
    check(ext_rst == 1'b0, "R9 idle level", ext_rst, 0);

    // R6 default duration 255 -> 256 ticks
    fire(256, 1'b1);
    repeat (5) @(negedge clk);
    check(ext_oe == 1'b1 && ext_rst == 1'b0, "R9 od during pulse", {ext_oe, ext_rst}, 2'b10);
    drain();

    // R2 / R5: no code in top byte, all ones
    reg_write(32'hFFFF_FFFF);
    @(negedge clk);
    check(rd_data == 32'h000F_FFFF, "R2 R5 field and gap", rd_data, 32'h000F_FFFF);

    // R3 active-high, R2 duration 3
    reg_write(32'hA500_0003);
    @(negedge clk);
    check(rd_data == 32'h8000_0003, "R3 act high", rd_data, 32'h8000_0003);
    m_high = 1'b1;
    // R4 push-pull
    reg_write(32'hA800_0003);
    @(negedge clk);
    check(rd_data == 32'hC000_0003, "R4 push pull", rd_data, 32'hC000_0003);
    m_pp = 1'b1;
    check(ext_oe == 1'b1 && ext_rst == 1'b0, "R8 pp idle", {ext_oe, ext_rst}, 2'b10);
    fire(4, 1'b1);
    repeat (3) @(negedge clk);
    check(ext_oe == 1'b1 && ext_rst == 1'b1, "R8 pp asserted", {ext_oe, ext_rst}, 2'b11);
    drain();

    // R3 active-low in push-pull
    reg_write(32'h5A00_0001);
    m_high = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h4000_0001, "R3 act low", rd_data, 32'h4000_0001);
    check(ext_rst == 1'b1 && ext_oe == 1'b1, "R8 pp low idle", {ext_oe, ext_rst}, 2'b11);
    fire(2, 1'b1);
    drain();

    // R5 other code keeps mode
    reg_write(32'h1234_0000);
    @(negedge clk);
    check(rd_data == 32'h4004_0000, "R5 keep mode", rd_data, 32'h4004_0000);

    // R4 open-drain, duration 0 -> 1 tick
    reg_write(32'h8A00_0000);
    m_pp = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h0000_0000, "R4 open drain", rd_data, 0);
    fire(1, 1'b1);
    drain();

    // R7 re-trigger and write during pulse
    reg_write(32'h0000_0005);
    fire(6, 1'b1);
    repeat (6) @(posedge clk);
    fire(0, 1'b0);
    reg_write(32'h0000_0002);
    drain();
    check(exp_q.size() == 0, "R7 single pulse", exp_q.size(), 0);
    fire(3, 1'b1);
    drain();
    check(ext_oe == 1'b0, "R9 idle after pulse", ext_oe, 0);

    summary();
  end
endmodule